// File: doc/BRIEF.md
# ADPCM Sample Streaming Accelerator

This block is a sample fetch engine that sits on a 16-bit processor register bus. Software first programs a start address, an end address and a current address into the block. It then loads a sample format, a predictor/scale field and a bank of eight signed coefficient pairs. From then on, every read of the sample register returns one decoded 16-bit sample taken from external sample memory. Each such read moves the current address forward by one unit. When the address runs past the end address, it is reloaded from the start address and a one-cycle loop interrupt is raised. This lets a looping instrument or sound effect be streamed with no further software work.

Three decode families are supported: 4-bit ADPCM with a second-order predictor, 8-bit PCM, and 16-bit PCM. There are also two raw unsigned read modes. A two-entry sample history is shifted on every sample read in every format, and it feeds the ADPCM predictor. A separate raw-word register reads or writes the memory word at the current address and then advances that address. The block does not decode samples until a write to the older history register starts it.

Sample memory is a synchronous single-port memory of 16-bit words with one cycle of read latency. Every bus read completes with a strobe. The master waits for that strobe before it issues the next access.

Top module: `adpcm_stream_accel`

## Requirements
- R1: After reset the following are all zero: every register, the history, the valid strobe and the loop interrupt. The block is stopped.
- R2: Start, end and current addresses are 32 bits wide. Each one is read and written as a high half (bits 31..16) and a low half (bits 15..0) at these offsets: start 0x12/0x13, end 0x14/0x15, current 0x16/0x17. Coefficients are at 0x00..0x0F, format at 0x10, predictor/scale at 0x11, history-1 at 0x18 and history-2 at 0x19.
- R3: A bus read accepted at a clock edge produces `bus_rvalid` high for exactly one cycle, after the second following edge, with `bus_rdata` valid in that cycle. Any bus read or write presented while a read is in flight is ignored.
- R4: A read of the sample register (0x1A) while the block is running returns the sample at the current address. It then increments the current address by one.
- R5: If the incremented address would exceed the end address (unsigned compare), the current address is reloaded from the start address instead. `loop_irq` then pulses for one cycle, in the same cycle as `bus_rvalid`.
- R6: The format register selects the decode. 0x19 gives 8-bit PCM, returned as the byte shifted left by 8. 0x0A and 0x06 give the 16-bit word. 0x05 gives the byte zero-extended. Any unlisted code reads the 16-bit word. Byte modes count the address in bytes, with the high byte of each word first. Word modes count it in words.
- R7: Format 0x00 is ADPCM. The address counts nibbles, high nibble first within each word, so sub-index 0 = bits 15..12. The sample is the signed nibble times 2^(s+11), plus A1·YN1, plus A2·YN2, plus 1024. This sum is arithmetically shifted right by 11 and saturated to signed 16 bits.
- R8: Predictor/scale bits 6..4 hold p, and bits 3..0 hold s. A1 is coefficient register 2p and A2 is 2p+1, both signed 16-bit.
- R9: On every running sample read, in every format, history-2 takes the old history-1 and history-1 takes the returned sample.
- R10: A write to history-2 starts the block. A sample read while stopped returns 0 and leaves both the address and the history unchanged.
- R11: A read of the raw-word register (0x1B) returns the memory word at the current address, used directly as a word index. A write to it stores the bus data there. Both then advance the address under the same wrap rule, and the memory read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read request |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| mem_rd_en | output | 1 | Sample memory read enable |
| mem_wr_en | output | 1 | Sample memory write enable |
| mem_addr | output | 32 | Sample memory word address |
| mem_wdata | output | 16 | Sample memory write data |
| mem_rdata | input | 16 | Sample memory read data, one cycle after mem_rd_en |
| loop_irq | output | 1 | Loop-wrap interrupt pulse |

## Verification
The sample path is driven with directed words whose nibble and byte patterns differ in every position. A swapped sub-index order, or a sign error in the byte or nibble extension, therefore produces a visibly wrong value. ADPCM is checked with a distinct coefficient in a pair other than the selected one, which exposes a wrong coefficient index. It is also driven at both saturation limits to separate clamping from plain truncation. A constrained-random run then mixes format, predictor/scale and coefficient changes over a short looping region. Every returned sample and wrap pulse is compared with a bench model, which exercises history shifting and reloads across format changes.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int DW         = 16;
    localparam int AW         = 32;
    localparam int REG_AW     = 5;
    localparam int COEF_PAIRS = 8;
    localparam int COEF_CNT   = 2 * COEF_PAIRS;
    localparam int COEF_IW    = $clog2(COEF_CNT);
    localparam int PRED_W     = $clog2(COEF_PAIRS);
    localparam int SCALE_W    = 4;
    localparam int PS_W       = PRED_W + SCALE_W;
    localparam int FRAC       = 11;
    localparam int ACC_W      = 48;

    localparam logic [REG_AW-1:0] OFS_FMT      = 5'h10;
    localparam logic [REG_AW-1:0] OFS_PS       = 5'h11;
    localparam logic [REG_AW-1:0] OFS_START_HI = 5'h12;
    localparam logic [REG_AW-1:0] OFS_CUR_LO   = 5'h17;
    localparam logic [REG_AW-1:0] OFS_HIST1    = 5'h18;
    localparam logic [REG_AW-1:0] OFS_HIST2    = 5'h19;
    localparam logic [REG_AW-1:0] OFS_SAMPLE   = 5'h1A;
    localparam logic [REG_AW-1:0] OFS_RAW      = 5'h1B;

    localparam logic [DW-1:0] FMT_ADPCM4 = 16'h0000;
    localparam logic [DW-1:0] FMT_PCM8   = 16'h0019;
    localparam logic [DW-1:0] FMT_PCM16  = 16'h000A;
    localparam logic [DW-1:0] FMT_RAW8   = 16'h0005;
    localparam logic [DW-1:0] FMT_RAW16  = 16'h0006;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RESOLVE} fsm_state_t;
    typedef enum logic [1:0] {K_REG, K_SAMPLE, K_STOPPED, K_RAWWORD} req_kind_t;
    typedef enum logic [1:0] {U_NIBBLE, U_BYTE, U_WORD} addr_unit_t;

    function automatic addr_unit_t fmt_unit(input logic [DW-1:0] fmt);
        if (fmt == FMT_ADPCM4)                      return U_NIBBLE;
        else if (fmt == FMT_PCM8 || fmt == FMT_RAW8) return U_BYTE;
        else                                         return U_WORD;
    endfunction

    function automatic logic [AW-1:0] word_index(input logic [DW-1:0] fmt,
                                                 input logic [AW-1:0] cur);
        unique case (fmt_unit(fmt))
            U_NIBBLE: return cur >> 2;
            U_BYTE:   return cur >> 1;
            default:  return cur;
        endcase
    endfunction
endpackage

// File: rtl/acc_coef_bank.sv
module acc_coef_bank
    import acc_pkg::*;
#(
    parameter int PAIRS = COEF_PAIRS,
    parameter int W     = DW,
    localparam int CNT  = 2 * PAIRS,
    localparam int IW   = $clog2(CNT),
    localparam int SW   = $clog2(PAIRS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [SW-1:0] pair_sel,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  a1,
    output logic [W-1:0]  a2,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] coef_flat [CNT];

    for (genvar i = 0; i < CNT; i++) begin : g_coef
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_idx == IW'(i))
                q <= wr_data;
        end
        assign coef_flat[i] = q;
    end

    assign a1      = coef_flat[{pair_sel, 1'b0}];
    assign a2      = coef_flat[{pair_sel, 1'b1}];
    assign rd_data = coef_flat[rd_idx];
endmodule

// File: rtl/acc_addr_unit.sv
module acc_addr_unit
    import acc_pkg::*;
#(
    parameter int A = AW,
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_field,
    input  logic [W-1:0] wr_data,
    input  logic         advance,
    output logic [A-1:0] start_addr,
    output logic [A-1:0] end_addr,
    output logic [A-1:0] cur_addr,
    output logic         wrap_irq
);
    localparam int NREG = 3;

    logic [A-1:0] regs_q [NREG];
    logic [A:0]   bumped;
    logic         passes_end;
    logic [1:0]   sel_reg;

    assign start_addr = regs_q[0];
    assign end_addr   = regs_q[1];
    assign cur_addr   = regs_q[2];

    assign bumped     = {1'b0, regs_q[2]} + {{A{1'b0}}, 1'b1};
    assign passes_end = bumped > {1'b0, regs_q[1]};
    assign sel_reg    = wr_field[2:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
            wrap_irq <= 1'b0;
        end else begin
            wrap_irq <= 1'b0;
            if (wr_en) begin
                for (int r = 0; r < NREG; r++) begin
                    if (sel_reg == 2'(r)) begin
                        if (wr_field[0]) regs_q[r][W-1:0] <= wr_data;
                        else             regs_q[r][A-1:W] <= wr_data;
                    end
                end
            end else if (advance) begin
                if (passes_end) begin
                    regs_q[2] <= regs_q[0];
                    wrap_irq  <= 1'b1;
                end else begin
                    regs_q[2] <= bumped[A-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/acc_sample_decode.sv
module acc_sample_decode
    import acc_pkg::*;
(
    input  logic [DW-1:0]      fmt,
    input  logic [1:0]         sub,
    input  logic [DW-1:0]      word,
    input  logic [DW-1:0]      a1,
    input  logic [DW-1:0]      a2,
    input  logic [DW-1:0]      h1,
    input  logic [DW-1:0]      h2,
    input  logic [SCALE_W-1:0] scale,
    output logic [DW-1:0]      sample
);
    logic [3:0]               nib;
    logic [7:0]               byte_sel;
    logic [5:0]               shamt;
    logic signed [2*DW-1:0]   m1, m2;
    logic signed [ACC_W-1:0]  base, acc, shr;
    logic [DW-1:0]            adpcm_val;

    always_comb begin
        unique case (sub)
            2'd0:    nib = word[15:12];
            2'd1:    nib = word[11:8];
            2'd2:    nib = word[7:4];
            default: nib = word[3:0];
        endcase
        byte_sel = sub[0] ? word[7:0] : word[15:8];
    end

    assign shamt = {2'b00, scale} + 6'(FRAC);
    assign m1    = $signed(a1) * $signed(h1);
    assign m2    = $signed(a2) * $signed(h2);

    always_comb begin
        base = $signed({{(ACC_W-4){nib[3]}}, nib}) <<< shamt;
        acc  = base
             + $signed({{(ACC_W-2*DW){m1[2*DW-1]}}, m1})
             + $signed({{(ACC_W-2*DW){m2[2*DW-1]}}, m2})
             + 48'sd1024;
        shr  = acc >>> FRAC;
        if (shr > 48'sd32767)
            adpcm_val = 16'h7FFF;
        else if (shr < -48'sd32768)
            adpcm_val = 16'h8000;
        else
            adpcm_val = shr[DW-1:0];
    end

    always_comb begin
        if (fmt == FMT_ADPCM4)     sample = adpcm_val;
        else if (fmt == FMT_PCM8)  sample = {byte_sel, 8'h00};
        else if (fmt == FMT_RAW8)  sample = {8'h00, byte_sel};
        else                       sample = word;
    end
endmodule

// File: rtl/adpcm_stream_accel.sv
module adpcm_stream_accel
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_rvalid,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              loop_irq
);
    fsm_state_t        state_q, state_nx;
    req_kind_t         kind_q;
    logic [DW-1:0]     reg_hold_q, reg_mux;
    logic [DW-1:0]     fmt_q;
    logic [PS_W-1:0]   ps_q;
    logic [DW-1:0]     hist1_q, hist2_q;
    logic              running_q;

    logic              wr_ok, rd_ok, is_coef, is_addr, advance, resolve_sample;
    logic [2:0]        addr_field;
    logic [AW-1:0]     start_addr, end_addr, cur_addr;
    logic [DW-1:0]     coef_a1, coef_a2, coef_rd, dec_sample;

    assign wr_ok      = bus_wr && state_q == S_IDLE;
    assign rd_ok      = bus_rd && state_q == S_IDLE;
    assign is_coef    = bus_addr < REG_AW'(COEF_CNT);
    assign is_addr    = bus_addr >= OFS_START_HI && bus_addr <= OFS_CUR_LO;
    assign addr_field = 3'(bus_addr - OFS_START_HI);
    assign resolve_sample = state_q == S_RESOLVE && kind_q == K_SAMPLE;
    assign advance    = resolve_sample
                     || (state_q == S_RESOLVE && kind_q == K_RAWWORD)
                     || (wr_ok && bus_addr == OFS_RAW);

    acc_addr_unit u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ok && is_addr),
        .wr_field   (addr_field),
        .wr_data    (bus_wdata),
        .advance    (advance),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .cur_addr   (cur_addr),
        .wrap_irq   (loop_irq)
    );

    acc_coef_bank u_coef (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok && is_coef),
        .wr_idx   (COEF_IW'(bus_addr)),
        .wr_data  (bus_wdata),
        .pair_sel (ps_q[PS_W-1:SCALE_W]),
        .rd_idx   (COEF_IW'(bus_addr)),
        .a1       (coef_a1),
        .a2       (coef_a2),
        .rd_data  (coef_rd)
    );

    acc_sample_decode u_dec (
        .fmt    (fmt_q),
        .sub    (cur_addr[1:0]),
        .word   (mem_rdata),
        .a1     (coef_a1),
        .a2     (coef_a2),
        .h1     (hist1_q),
        .h2     (hist2_q),
        .scale  (ps_q[SCALE_W-1:0]),
        .sample (dec_sample)
    );

    // Register read mux, captured at request time
    always_comb begin
        reg_mux = '0;
        if (is_coef) begin
            reg_mux = coef_rd;
        end else begin
            unique case (bus_addr)
                OFS_FMT:      reg_mux = fmt_q;
                OFS_PS:       reg_mux = DW'(ps_q);
                5'h12:        reg_mux = start_addr[AW-1:DW];
                5'h13:        reg_mux = start_addr[DW-1:0];
                5'h14:        reg_mux = end_addr[AW-1:DW];
                5'h15:        reg_mux = end_addr[DW-1:0];
                5'h16:        reg_mux = cur_addr[AW-1:DW];
                OFS_CUR_LO:   reg_mux = cur_addr[DW-1:0];
                OFS_HIST1:    reg_mux = hist1_q;
                OFS_HIST2:    reg_mux = hist2_q;
                default:      reg_mux = '0;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:    if (bus_rd) state_nx = S_ISSUE;
            S_ISSUE:   state_nx = S_RESOLVE;
            S_RESOLVE: state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q     <= K_REG;
            reg_hold_q <= '0;
        end else if (rd_ok) begin
            reg_hold_q <= reg_mux;
            if (bus_addr == OFS_SAMPLE)
                kind_q <= running_q ? K_SAMPLE : K_STOPPED;
            else if (bus_addr == OFS_RAW)
                kind_q <= K_RAWWORD;
            else
                kind_q <= K_REG;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= state_q == S_RESOLVE;
            if (state_q == S_RESOLVE) begin
                unique case (kind_q)
                    K_SAMPLE:  bus_rdata <= dec_sample;
                    K_RAWWORD: bus_rdata <= mem_rdata;
                    K_REG:     bus_rdata <= reg_hold_q;
                    default:   bus_rdata <= '0;
                endcase
            end
        end
    end

    // Configuration, history and run flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q     <= '0;
            ps_q      <= '0;
            hist1_q   <= '0;
            hist2_q   <= '0;
            running_q <= 1'b0;
        end else if (resolve_sample) begin
            hist2_q <= hist1_q;
            hist1_q <= dec_sample;
        end else if (wr_ok) begin
            unique case (bus_addr)
                OFS_FMT:   fmt_q   <= bus_wdata;
                OFS_PS:    ps_q    <= bus_wdata[PS_W-1:0];
                OFS_HIST1: hist1_q <= bus_wdata;
                OFS_HIST2: begin
                    hist2_q   <= bus_wdata;
                    running_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign mem_rd_en = state_q == S_ISSUE && (kind_q == K_SAMPLE || kind_q == K_RAWWORD);
    assign mem_wr_en = wr_ok && bus_addr == OFS_RAW;
    assign mem_wdata = bus_wdata;
    assign mem_addr  = (state_q == S_ISSUE && kind_q == K_SAMPLE)
                     ? word_index(fmt_q, cur_addr) : cur_addr;
endmodule

// File: rtl/acc_checker.sv
module acc_checker
    import acc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rvalid,
    input logic          loop_irq,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [AW-1:0] cur_addr,
    input logic [AW-1:0] start_addr
);
    a_r3_valid_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ##2 bus_rvalid);

    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);

    a_r3_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    a_r5_reload_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_irq && bus_rvalid) |-> cur_addr == start_addr);

    a_r11_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        loop_irq |-> (bus_rvalid || $past(mem_wr_en)));
endmodule

bind adpcm_stream_accel acc_checker u_acc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rvalid (bus_rvalid),
    .loop_irq   (loop_irq),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .cur_addr   (cur_addr),
    .start_addr (start_addr)
);

// File: tb/adpcm_stream_accel_bench.sv
`timescale 1ns/1ps
module adpcm_stream_accel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid, mem_rd_en, mem_wr_en, loop_irq;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    adpcm_stream_accel u_adpcm_stream_accel (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .loop_irq(loop_irq)
    );

    logic [15:0] bench_mem [256];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= bench_mem[mem_addr[7:0]];
        if (mem_wr_en) bench_mem[mem_addr[7:0]] <= mem_wdata;
    end

    // Bench model
    logic [31:0] m_start = 0, m_end = 0, m_cur = 0;
    logic [15:0] m_fmt = 0, m_h1 = 0, m_h2 = 0;
    logic [6:0]  m_ps = 0;
    logic [15:0] m_coef [16];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        if (a < 16) m_coef[a[3:0]] = d;
        case (a)
            5'h10: m_fmt = d;
            5'h11: m_ps = d[6:0];
            5'h12: m_start[31:16] = d;
            5'h13: m_start[15:0] = d;
            5'h14: m_end[31:16] = d;
            5'h15: m_end[15:0] = d;
            5'h16: m_cur[31:16] = d;
            5'h17: m_cur[15:0] = d;
            5'h18: m_h1 = d;
            5'h19: m_h2 = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d, output logic irq);
        bit early;
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; early = bus_rvalid;
        @(negedge clk); early = early | bus_rvalid;
        @(negedge clk);
        if (early || !bus_rvalid) check(1'b0, "R3 valid timing", {31'd0, bus_rvalid}, 1);
        d = bus_rdata; irq = loop_irq;
    endtask

    task automatic set_addr(input logic [4:0] hi, input logic [31:0] v);
        bus_write(hi, v[31:16]);
        bus_write(hi + 5'd1, v[15:0]);
    endtask

    function automatic logic [15:0] exp_sample();
        logic [31:0] wi;
        logic [15:0] w;
        logic [7:0]  b;
        logic [3:0]  nb;
        longint n, a1, a2, acc, r;
        int p, s;
        if (m_fmt == 16'h0000) wi = m_cur >> 2;
        else if (m_fmt == 16'h0019 || m_fmt == 16'h0005) wi = m_cur >> 1;
        else wi = m_cur;
        w  = bench_mem[wi[7:0]];
        b  = m_cur[0] ? w[7:0] : w[15:8];
        nb = 4'((w >> (12 - 4 * int'(m_cur[1:0]))) & 16'hF);
        if (m_fmt == 16'h0000) begin
            p  = int'(m_ps[6:4]);
            s  = int'(m_ps[3:0]);
            n  = (nb >= 8) ? longint'(nb) - 16 : longint'(nb);
            a1 = longint'($signed(m_coef[2*p]));
            a2 = longint'($signed(m_coef[2*p+1]));
            acc = n * (64'sd1 <<< (s + 11)) + a1 * longint'($signed(m_h1))
                + a2 * longint'($signed(m_h2)) + 1024;
            r = acc >>> 11;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            return 16'(r);
        end else if (m_fmt == 16'h0019) return {b, 8'h00};
        else if (m_fmt == 16'h0005) return {8'h00, b};
        else return w;
    endfunction

    function automatic bit model_advance();
        if ({1'b0, m_cur} + 33'd1 > {1'b0, m_end}) begin
            m_cur = m_start;
            return 1'b1;
        end
        m_cur = m_cur + 1;
        return 1'b0;
    endfunction

    // Running sample read checked against the model
    task automatic sample_read_check(input string req);
        logic [15:0] d, e;
        logic irq;
        bit eirq;
        e = exp_sample();
        bus_read(5'h1A, d, irq);
        eirq = model_advance();
        m_h2 = m_h1; m_h1 = e;
        check(d == e, req, {16'd0, d}, {16'd0, e});
        check(irq == eirq, "R5 irq", {31'd0, irq}, {31'd0, eirq});
    endtask

    logic [15:0] rd_d;
    logic        rd_irq;
    logic [15:0] fmts [5];

    initial begin
        void'($urandom(32'h1234));
        for (int i = 0; i < 256; i++) bench_mem[i] = 16'($urandom);
        for (int i = 0; i < 16; i++) m_coef[i] = 16'h0;
        fmts[0] = 16'h0000; fmts[1] = 16'h0019; fmts[2] = 16'h000A;
        fmts[3] = 16'h0005; fmts[4] = 16'h0006;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(bus_rvalid == 0 && loop_irq == 0, "R1 outputs idle", {30'd0, bus_rvalid, loop_irq}, 0);
        bus_read(5'h17, rd_d, rd_irq);
        check(rd_d == 0, "R1 cur_lo", {16'd0, rd_d}, 0);
        bus_read(5'h10, rd_d, rd_irq);
        check(rd_d == 0, "R1 fmt", {16'd0, rd_d}, 0);

        // R2 address registers
        set_addr(5'h12, 32'h1234_5678);
        set_addr(5'h14, 32'h9ABC_DEF0);
        bus_read(5'h12, rd_d, rd_irq);
        check(rd_d == 16'h1234, "R2 start_hi", {16'd0, rd_d}, 32'h1234);
        bus_read(5'h15, rd_d, rd_irq);
        check(rd_d == 16'hDEF0, "R2 end_lo", {16'd0, rd_d}, 32'hDEF0);

        // R10 stopped block
        set_addr(5'h12, 32'h0);
        set_addr(5'h14, 32'h3FF);
        set_addr(5'h16, 32'h5);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 0, "R10 stopped read", {16'd0, rd_d}, 0);
        bus_read(5'h17, rd_d, rd_irq);
        check(rd_d == 16'h5, "R10 address held", {16'd0, rd_d}, 5);
        bus_read(5'h18, rd_d, rd_irq);
        check(rd_d == 0, "R10 history held", {16'd0, rd_d}, 0);

        // Start; R4 16-bit read
        bus_write(5'h10, 16'h000A);
        bus_write(5'h19, 16'h0000);
        bench_mem[5] = 16'hC3A5;
        sample_read_check("R4 pcm16 sample");
        bus_read(5'h17, rd_d, rd_irq);
        check(rd_d == 16'h6, "R4 increment", {16'd0, rd_d}, 6);
        bus_read(5'h19, rd_d, rd_irq);
        check(rd_d == 16'h0 && m_h1 == 16'hC3A5, "R9 hist2 shift", {16'd0, rd_d}, 0);

        // R5 wrap
        set_addr(5'h12, 32'h10);
        set_addr(5'h14, 32'h11);
        set_addr(5'h16, 32'h11);
        sample_read_check("R5 sample at end");
        bus_read(5'h17, rd_d, rd_irq);
        check(rd_d == 16'h10, "R5 reload", {16'd0, rd_d}, 32'h10);
        sample_read_check("R5 sample after reload");

        // R6 byte modes, high byte first
        set_addr(5'h14, 32'h3FF);
        bench_mem[8'h40] = 16'h817F;
        bus_write(5'h10, 16'h0019);
        set_addr(5'h16, 32'h80);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'h8100, "R6 pcm8 high byte", {16'd0, rd_d}, 32'h8100);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'h7F00, "R6 pcm8 low byte", {16'd0, rd_d}, 32'h7F00);
        bus_read(5'h18, rd_d, rd_irq);
        check(rd_d == 16'h7F00, "R9 hist1 pcm8", {16'd0, rd_d}, 32'h7F00);
        bus_read(5'h19, rd_d, rd_irq);
        check(rd_d == 16'h8100, "R9 hist2 pcm8", {16'd0, rd_d}, 32'h8100);
        bus_write(5'h10, 16'h0005);
        set_addr(5'h16, 32'h80);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'h0081, "R6 raw8", {16'd0, rd_d}, 32'h0081);
        bus_write(5'h10, 16'h0003);
        set_addr(5'h16, 32'h40);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'h817F, "R6 unlisted as word", {16'd0, rd_d}, 32'h817F);

        // R7 nibble order, s=0, pair 0 zero
        bus_write(5'h10, 16'h0000);
        bus_write(5'h11, 16'h0000);
        bench_mem[8'h30] = 16'h3A5C;
        set_addr(5'h16, 32'hC0);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'h0003, "R7 nibble 0", {16'd0, rd_d}, 3);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'hFFFA, "R7 nibble 1", {16'd0, rd_d}, 32'hFFFA);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'h0005, "R7 nibble 2", {16'd0, rd_d}, 5);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'hFFFC, "R7 nibble 3", {16'd0, rd_d}, 32'hFFFC);

        // R8 predictor pair 5, s=2
        bus_write(5'h00, 16'h1000);
        bus_write(5'h0A, 16'h0800);
        bus_write(5'h0B, 16'h0400);
        bus_write(5'h11, 16'h0052);
        bus_write(5'h18, 16'd100);
        bus_write(5'h19, 16'd40);
        bench_mem[8'h31] = 16'h0100;
        set_addr(5'h16, 32'hC4);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'd120, "R8 pair select", {16'd0, rd_d}, 120);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'd174, "R8 scale", {16'd0, rd_d}, 174);

        // R7 saturation both ways
        bus_write(5'h06, 16'h7FFF);
        bus_write(5'h07, 16'h7FFF);
        bus_write(5'h11, 16'h003F);
        bus_write(5'h18, 16'h7FFF);
        bus_write(5'h19, 16'h7FFF);
        bench_mem[8'h20] = 16'h78FF;
        set_addr(5'h16, 32'h80);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'h7FFF, "R7 positive clamp", {16'd0, rd_d}, 32'h7FFF);
        bus_write(5'h00, 16'h0000);
        bus_write(5'h01, 16'h0000);
        bus_write(5'h11, 16'h000F);
        bus_read(5'h1A, rd_d, rd_irq);
        check(rd_d == 16'h8000, "R7 negative clamp", {16'd0, rd_d}, 32'h8000);

        // R3 write during a read in flight is ignored
        bus_write(5'h10, 16'h000A);
        set_addr(5'h16, 32'h22);
        @(negedge clk); bus_addr = 5'h1A; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; bus_addr = 5'h10; bus_wdata = 16'h0019; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
        bus_read(5'h10, rd_d, rd_irq);
        check(rd_d == 16'h000A, "R3 busy write ignored", {16'd0, rd_d}, 32'h000A);

        // R11 raw word register
        bench_mem[8'h40] = 16'h5A5A;
        set_addr(5'h16, 32'h40);
        bus_write(5'h10, 16'h0000);
        bus_read(5'h1B, rd_d, rd_irq);
        check(rd_d == 16'h5A5A, "R11 raw read", {16'd0, rd_d}, 32'h5A5A);
        bus_write(5'h1B, 16'hBEEF);
        @(negedge clk);
        check(bench_mem[8'h41] == 16'hBEEF, "R11 raw write", {16'd0, bench_mem[8'h41]}, 32'hBEEF);
        bus_read(5'h17, rd_d, rd_irq);
        check(rd_d == 16'h42, "R11 advance", {16'd0, rd_d}, 32'h42);

        // Random mix; resync model history and coefs from known writes
        for (int i = 0; i < 16; i++) bus_write(5'(i), 16'($urandom));
        bus_write(5'h18, 16'($urandom));
        bus_write(5'h19, 16'($urandom));
        set_addr(5'h12, 32'h100);
        set_addr(5'h14, 32'h100 + 32'($urandom % 48));
        set_addr(5'h16, 32'h100);
        bus_write(5'h10, 16'h0000);
        for (int it = 0; it < 400; it++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 2)       bus_write(5'h10, fmts[$urandom % 5]);
            else if (r == 2) bus_write(5'h11, 16'($urandom % 128));
            else if (r == 3) bus_write(5'($urandom % 16), 16'($urandom));
            sample_read_check("R6 R7 R9 random sample");
        end
        bus_read(5'h17, rd_d, rd_irq);
        check(rd_d == m_cur[15:0], "R4 final address", {16'd0, rd_d}, {16'd0, m_cur[15:0]});

        report();
    end
endmodule